// File: doc/BRIEF.md
# Third-Order Fractional-N Divide Ratio Generator

This block produces, once per feedback-divider cycle, the whole-number ratio that a fractional-N synthesizer's feedback divider should use next. The ratio is an integer setting plus a small signed correction. The correction comes from three cascaded accumulators whose carries are combined into a third-order noise-shaped sequence. Over time, the mean ratio tends to the integer setting plus the fraction setting divided by a fixed modulus of 2^FRAC_W. With the default 25-bit fraction, the frequency step is the phase-detector rate divided by 2^25. At 10 MHz, that step is roughly 0.298 Hz.

The clock advances by one tick per divider cycle. A new integer/fraction pair is taken only on a load strobe, and only if the integer lies within its legal range. Accumulator state carries across loads, so a retune does not restart the noise shaper. Only a reset clears that state.

Top module: `fracn_ratio_gen`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `div_out` is INT_MIN (23) and `int_bad` is 0. The accumulators and carry history are cleared, and the held fraction is 0.
- R2: On each tick, stage 1 adds the held fraction to its accumulator. Stage 2 adds stage 1's new sum, and stage 3 adds stage 2's new sum. Each stage wraps modulo 2^FRAC_W and raises its carry (c1, c2, c3) when the unwrapped sum reaches 2^FRAC_W.
- R3: The correction is c1 + c2 − c2' + c3 − 2·c3' + c3''. Here a prime marks the carry from one tick earlier, and a double prime marks the carry from two ticks earlier. `div_out` is registered, so it shows the held integer plus the correction computed at the same clock edge.
- R4: The correction always lies between −3 and +4 inclusive.
- R5: When the fraction is 0 and starts from the cleared state, `div_out` equals the held integer on every tick.
- R6: Starting from the cleared state with a fraction F held, the corrections over 2^FRAC_W consecutive ticks sum to a value between F−1 and F+2.
- R7: `int_in` and `frac_in` are captured only at a clock edge where `load` is high. The output computed at that same edge still uses the previous pair. A load does not alter accumulator state.
- R8: A load with `int_in` below INT_MIN (23) is rejected: both held values stay unchanged and `int_bad` goes to 1. The next accepted load clears `int_bad`. The values 23 and 4095 are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | One rising edge per feedback-divider cycle |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for `int_in` and `frac_in` |
| int_in | input | 12 | Integer part of the ratio (legal 23 to 4095) |
| frac_in | input | 25 | Fraction numerator over 2^25 |
| div_out | output | 13 | Instantaneous divide ratio, integer plus correction |
| int_bad | output | 1 | Last load carried an illegal integer and was refused |

## Verification
The bench runs a 6-bit-fraction build. Starting from reset, it sweeps every fraction value from 0 to 63 and compares each output tick against an arithmetic model of the three wrapping accumulators. This pins down the carry timing of each stage and the sign of each delayed term. Over each full modulus window, the bench also sums the corrections. A wrong carry weighting would still keep the output in range, but it shifts this sum away from F.

A zero fraction separates a clean pass-through from stray carries. Mid-run retunes without reset show whether state is kept, and whether the load-edge output still uses the previous pair. Integers of 22, 23 and 4095 check where the accept/reject boundary falls.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  localparam int NSTAGE = 3;

  typedef logic signed [3:0] offs_t;

  // Third-order carry combination; every term is widened before summing.
  function automatic offs_t mash_offset(input logic c1, input logic c2,
                                        input logic c2_d, input logic c3,
                                        input logic c3_d, input logic c3_dd);
    offs_t t;
    t = offs_t'({3'b000, c1})
      + offs_t'({3'b000, c2}) - offs_t'({3'b000, c2_d})
      + offs_t'({3'b000, c3}) - offs_t'({2'b00, c3_d, 1'b0})
      + offs_t'({3'b000, c3_dd});
    return t;
  endfunction

  function automatic logic int_legal(input int unsigned v, input int unsigned lo,
                                     input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/fracn_acc_stage.sv
module fracn_acc_stage #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum_nxt,
  output logic         carry,
  output logic [W-1:0] acc_q
);

  logic [W:0] wide;

  assign wide    = {1'b0, acc_q} + {1'b0, addend};
  assign sum_nxt = wide[W-1:0];
  assign carry   = wide[W];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= sum_nxt;
  end

  // R2: a carry means the stored sum wrapped below the addend
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    carry |-> (sum_nxt < addend));

  // R2: no carry means the sum did not shrink
  p_nowrap_r2: assert property (@(posedge clk) disable iff (rst)
    !carry |-> (sum_nxt >= acc_q));

endmodule

// File: rtl/fracn_carry_net.sv
module fracn_carry_net
  import fracn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTAGE-1:0] carries,
  output offs_t             offset,
  output logic              hist_clear
);

  logic c2_d, c3_d, c3_dd;

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else begin
      c2_d  <= carries[1];
      c3_d  <= carries[2];
      c3_dd <= c3_d;
    end
  end

  assign offset     = mash_offset(carries[0], carries[1], c2_d, carries[2], c3_d, c3_dd);
  assign hist_clear = !(c2_d || c3_d || c3_dd);

  // R4: correction stays inside -3..+4
  p_offset_range_r4: assert property (@(posedge clk) disable iff (rst)
    (offset >= -4'sd3) && (offset <= 4'sd4));

  // R3: the two-tick-old stage-3 carry tracks the one-tick-old copy
  p_delay_chain_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (c3_dd == $past(c3_d)));

endmodule

// File: rtl/fracn_ratio_gen.sv
module fracn_ratio_gen
  import fracn_pkg::*;
#(
  parameter int INT_W   = 12,
  parameter int FRAC_W  = 25,
  parameter int INT_MIN = 23,
  parameter int INT_MAX = (1 << INT_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [INT_W:0]    div_out,
  output logic              int_bad
);

  localparam int OUT_W = INT_W + 1;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              load_ok;

  logic [FRAC_W-1:0] addend  [NSTAGE];
  logic [FRAC_W-1:0] sum_nxt [NSTAGE];
  logic [FRAC_W-1:0] acc_q   [NSTAGE];
  logic [NSTAGE-1:0] carries;
  logic [NSTAGE-1:0] acc_zero;
  logic              accs_clear;
  logic              hist_clear;
  offs_t             offset;
  logic [OUT_W-1:0]  ratio_nxt;

  assign load_ok = int_legal(32'(int_in), INT_MIN, INT_MAX);

  // Held configuration: only a legal load replaces it
  always_ff @(posedge clk) begin
    if (rst) begin
      int_q   <= INT_W'(INT_MIN);
      frac_q  <= '0;
      int_bad <= 1'b0;
    end else if (load) begin
      if (load_ok) begin
        int_q   <= int_in;
        frac_q  <= frac_in;
        int_bad <= 1'b0;
      end else begin
        int_bad <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign addend[g] = frac_q;
    end else begin : g_chain
      assign addend[g] = sum_nxt[g-1];
    end
    fracn_acc_stage #(.W(FRAC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .addend  (addend[g]),
      .sum_nxt (sum_nxt[g]),
      .carry   (carries[g]),
      .acc_q   (acc_q[g])
    );
    assign acc_zero[g] = (acc_q[g] == '0);
  end

  assign accs_clear = &acc_zero;

  fracn_carry_net u_net (
    .clk        (clk),
    .rst        (rst),
    .carries    (carries),
    .offset     (offset),
    .hist_clear (hist_clear)
  );

  assign ratio_nxt = {1'b0, int_q} + {{(OUT_W-4){offset[3]}}, offset};

  always_ff @(posedge clk) begin
    if (rst) div_out <= OUT_W'(INT_MIN);
    else     div_out <= ratio_nxt;
  end

  // R7: held values change only on a load
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(int_q) && $stable(frac_q)));

  // R7: a legal load is captured and clears the flag
  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (load && (int_in >= INT_W'(INT_MIN))) |=> ((int_q == $past(int_in)) && !int_bad));

  // R8: an illegal integer is refused and flagged
  p_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (load && (int_in < INT_W'(INT_MIN))) |=> (int_bad && $stable(int_q) && $stable(frac_q)));

  // R5: zero fraction from a clean state passes the integer straight through
  p_frac_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ((frac_q == '0) && accs_clear && hist_clear) |=> (div_out == {1'b0, $past(int_q)}));

endmodule

// File: tb/tb_fracn_ratio_gen.sv
module tb_fracn_ratio_gen;

  localparam int FW   = 6;
  localparam int M    = 1 << FW;
  localparam int IMIN = 23;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [11:0]   int_in = '0;
  logic [FW-1:0] frac_in = '0;
  logic [12:0]   div_out;
  logic          int_bad;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // Independent arithmetic model
  int m_a1, m_a2, m_a3, m_c2d, m_c3d, m_c3dd;
  int m_int, m_frac, m_out, m_off;
  bit m_bad;

  always #4 clk = ~clk;

  fracn_ratio_gen #(.INT_W(12), .FRAC_W(FW)) dut (
    .clk(clk), .rst(rst), .load(load), .int_in(int_in),
    .frac_in(frac_in), .div_out(div_out), .int_bad(int_bad)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_a1 = 0; m_a2 = 0; m_a3 = 0;
    m_c2d = 0; m_c3d = 0; m_c3dd = 0;
    m_int = IMIN; m_frac = 0; m_out = IMIN; m_off = 0; m_bad = 0;
  endtask

  task automatic model_step(input bit ld, input int iv, input int fv);
    int s, c1, c2, c3;
    s = m_a1 + m_frac; c1 = s / M; m_a1 = s % M;
    s = m_a2 + m_a1;   c2 = s / M; m_a2 = s % M;
    s = m_a3 + m_a2;   c3 = s / M; m_a3 = s % M;
    m_off = c1 + (c2 - m_c2d) + (c3 - 2 * m_c3d + m_c3dd);
    m_out = m_int + m_off;
    m_c2d = c2; m_c3dd = m_c3d; m_c3d = c3;
    if (ld) begin
      if (iv >= IMIN) begin m_int = iv; m_frac = fv; m_bad = 0; end
      else m_bad = 1;
    end
  endtask

  // One tick: drive at negedge, step model at the edge, sample at the next negedge
  task automatic tick(input bit ld, input int iv, input int fv, input string req);
    load = ld; int_in = 12'(iv); frac_in = FW'(fv);
    @(posedge clk);
    model_step(ld, iv, fv);
    @(negedge clk);
    load = 1'b0;
    check(req, int'(div_out), m_out);
    check(req, int'(int_bad), int'(m_bad));
  endtask

  task automatic do_reset();
    rst = 1'b1; load = 1'b0;
    @(posedge clk);
    @(negedge clk);
    model_reset();
    rst = 1'b0;
  endtask

  initial begin
    int sum, lo_off, hi_off;
    @(negedge clk);
    do_reset();
    // R1: reset state
    check("R1", int'(div_out), IMIN);
    check("R1", int'(int_bad), 0);

    // R5: zero fraction from clean state
    tick(1'b1, 100, 0, "R5");
    for (int k = 0; k < 20; k++) begin
      tick(1'b0, 0, 0, "R5");
      check("R5", int'(div_out), 100);
    end

    // R2 R3 R4 R6: sweep every fraction from reset
    for (int f = 0; f < M; f++) begin
      do_reset();
      check("R1", int'(div_out), IMIN);
      tick(1'b1, 200, f, "R7");
      check("R7", int'(div_out), IMIN);  // load edge still uses old pair
      sum = 0; lo_off = 0; hi_off = 0;
      for (int k = 0; k < M; k++) begin
        tick(1'b0, 0, 0, "R3");
        sum += int'(div_out) - 200;
        if (int'(div_out) - 200 < lo_off) lo_off = int'(div_out) - 200;
        if (int'(div_out) - 200 > hi_off) hi_off = int'(div_out) - 200;
      end
      check("R4", int'(lo_off >= -3 && hi_off <= 4), 1);
      check("R6", int'(sum >= f - 1 && sum <= f + 2), 1);
      for (int k = 0; k < 4; k++) tick(1'b0, 0, 0, "R2");
    end

    // R7: retune mid-run without reset, state carried across
    do_reset();
    tick(1'b1, 500, 37, "R7");
    for (int k = 0; k < 13; k++) tick(1'b0, 0, 0, "R7");
    tick(1'b1, 777, 5, "R7");
    for (int k = 0; k < 30; k++) tick(1'b0, 0, 0, "R7");
    tick(1'b1, 300, 0, "R7");
    for (int k = 0; k < 30; k++) tick(1'b0, 0, 0, "R7");

    // R8: illegal integer refused, boundaries accepted
    tick(1'b1, 22, 11, "R8");
    check("R8", int'(int_bad), 1);
    for (int k = 0; k < 10; k++) tick(1'b0, 0, 0, "R8");
    tick(1'b1, 0, 63, "R8");
    tick(1'b1, 23, 63, "R8");
    check("R8", int'(int_bad), 0);
    for (int k = 0; k < 20; k++) tick(1'b0, 0, 0, "R8");
    tick(1'b1, 4095, 49, "R8");
    for (int k = 0; k < 40; k++) tick(1'b0, 0, 0, "R8");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule